// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block turns pin transitions on up to five 16-bit GPIO ports into pending flags and interrupt request pulses. There are sixteen lines. A packed selection input assigns each line to one port. Line N watches only pin N of its assigned port. When the watched pin moves in a direction the line is armed for, and the line is unmasked, the line's pending bit is set. In the same cycle, a one-cycle pulse is sent out on the request output of the line's group.

Software controls the block through a word-wide register bus. Through it, software arms each line, picks the rising or falling direction (or both), and can fire a line on its own without a pin edge. Software acknowledges a line by writing a one to its pending bit. Pin edges are found inside the block by comparing each pin with the level it had on the previous clock. The active-low reset is applied asynchronously and released in step with the clock.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 (line enable), 0x04 (event mask), 0x08 (rising arm), 0x0C (falling arm), 0x10 (software fire) and 0x14 (pending). Bits 15:0 hold line 0..15. Any other offset reads zero. After reset, every register, `pend_status` and `irq_pulse` read zero.
- R2: A write to the pending register clears each bit written as 1. Bits written as 0 are left unchanged.
- R3: Line N is assigned a port by the 4-bit field at bits N*4+3 .. N*4 of `port_sel`. Codes 0..4 select ports 0..4, and port P is bits P*16+15 .. P*16 of `pin_level`. Codes 5..15 select no port.
- R4: An edge on pin N of any port other than the one selected for line N has no effect.
- R5: A line fires only if its enable bit is set and the edge direction matches an armed direction. A line armed only for falling edges ignores a rising edge, and the reverse also holds.
- R6: `irq_pulse` bits 0..4 belong to lines 0..4 (request numbers 6..10). Bit 5 is shared by lines 5..9 (request 23). Bit 6 is shared by lines 10..15 (request 40).
- R7: The event mask register stores all 32 bits written to it and reads them back. It has no effect on pending bits or requests.
- R8: Writing 1 to a software-fire bit fires that line exactly as a pin edge would, but only if the line's enable bit is set. The software-fire bit reads back as 1 until the matching pending bit is cleared.
- R9: A pin change is seen against the level registered on the previous clock. The pending bit and request pulse appear one clock after the change. The pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_level | input | 80 | Pin levels, 16 per port, 5 ports |
| port_sel | input | 64 | Per-line port code, 4 bits per line |
| pend_status | output | 16 | Pending bit per line |
| irq_pulse | output | 7 | One-cycle request pulse per line group |

## Verification
The hardest case to reach is a pin edge that must be ignored. The edge is still real, so the bench must show that nothing changed. To do this, a table of vectors prepares each case first: it settles the pin at its starting level while the line is disabled, clears any stale pending bits, and only then enables the line and flips one pin. Routing is checked by flipping the correct pin number on the wrong port. The bench also uses a port code that selects no port at all. Direction filtering is checked by giving a line armed for one direction an edge in the other. For every vector, the pending word and the request output are read one clock after the change, and the request output is read again a clock later to confirm the pulse has ended.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int LINES_DEF   = 16;
  localparam int PORTS_DEF   = 5;
  localparam int PORT_W      = 16;
  localparam int SEL_W       = 4;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 32;
  localparam int GROUPS      = 7;
  localparam int SOLO_LINES  = 5;   // lines with their own request
  localparam int MID_LAST    = 9;   // last line of the middle shared group

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_EVMASK = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_RISE   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_FALL   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_SWFIRE = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 6'h14;

  function automatic int unsigned line_group(input int unsigned line);
    if (line < SOLO_LINES)       return line;
    else if (line <= MID_LAST)   return SOLO_LINES;
    else                         return SOLO_LINES + 1;
  endfunction

  function automatic logic [31:0] group_members(input int unsigned grp,
                                                input int unsigned lines);
    logic [31:0] m;
    m = '0;
    for (int unsigned l = 0; l < lines; l++)
      if (line_group(l) == grp) m[l] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic         prev_en;

  always_comb begin
    prev_d  = level;
    prev_en = 1'b1;
    rise    = level & ~prev_q;
    fall    = ~level & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end
endmodule

// File: rtl/eic_line_router.sv
module eic_line_router #(
  parameter int LINES  = 16,
  parameter int PORTS  = 5,
  parameter int PORT_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic [PORTS*PORT_W-1:0] rise_all,
  input  logic [PORTS*PORT_W-1:0] fall_all,
  input  logic [LINES*SEL_W-1:0]  port_sel,
  output logic [LINES-1:0]        line_rise,
  output logic [LINES-1:0]        line_fall
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = port_sel[n*SEL_W +: SEL_W];

    always_comb begin
      line_rise[n] = 1'b0;
      line_fall[n] = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
        if (code == SEL_W'(p)) begin
          line_rise[n] = rise_all[p*PORT_W + n];
          line_fall[n] = fall_all[p*PORT_W + n];
        end
      end
    end
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import edge_irq_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LINES-1:0]  line_rise,
  input  logic [LINES-1:0]  line_fall,
  output logic [LINES-1:0]  fire,
  output logic [LINES-1:0]  enable_q,
  output logic [LINES-1:0]  pend_q
);
  logic [DATA_W-1:0] evmask_q, evmask_d;
  logic [LINES-1:0]  rise_q, rise_d, fall_q, fall_d, swf_q, swf_d;
  logic [LINES-1:0]  enable_d, pend_d;
  logic [LINES-1:0]  wbits, clr, sw_fire, hw_fire, swf_set;
  logic              en_enable, en_evmask, en_rise, en_fall, en_swf, en_pend;

  always_comb begin
    wbits     = reg_wdata[LINES-1:0];
    en_enable = reg_wr && (reg_addr == OFF_ENABLE);
    en_evmask = reg_wr && (reg_addr == OFF_EVMASK);
    en_rise   = reg_wr && (reg_addr == OFF_RISE);
    en_fall   = reg_wr && (reg_addr == OFF_FALL);

    enable_d  = wbits;
    evmask_d  = reg_wdata;
    rise_d    = wbits;
    fall_d    = wbits;

    swf_set   = (reg_wr && (reg_addr == OFF_SWFIRE)) ? wbits : '0;
    clr       = (reg_wr && (reg_addr == OFF_PEND))   ? wbits : '0;

    sw_fire   = swf_set & enable_q;
    hw_fire   = enable_q & ((line_rise & rise_q) | (line_fall & fall_q));
    fire      = sw_fire | hw_fire;

    // a new firing wins over a clear in the same cycle
    pend_d    = (pend_q & ~clr) | fire;
    swf_d     = (swf_q | swf_set) & ~clr;
    en_pend   = 1'b1;
    en_swf    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      evmask_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      swf_q    <= '0;
      pend_q   <= '0;
    end else begin
      if (en_enable) enable_q <= enable_d;
      if (en_evmask) evmask_q <= evmask_d;
      if (en_rise)   rise_q   <= rise_d;
      if (en_fall)   fall_q   <= fall_d;
      if (en_swf)    swf_q    <= swf_d;
      if (en_pend)   pend_q   <= pend_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_ENABLE: reg_rdata = DATA_W'(enable_q);
      OFF_EVMASK: reg_rdata = evmask_q;
      OFF_RISE:   reg_rdata = DATA_W'(rise_q);
      OFF_FALL:   reg_rdata = DATA_W'(fall_q);
      OFF_SWFIRE: reg_rdata = DATA_W'(swf_q);
      OFF_PEND:   reg_rdata = DATA_W'(pend_q);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eic_irq_group.sv
module eic_irq_group
  import edge_irq_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] fire,
  output logic [GROUPS-1:0] irq_q
);
  logic [GROUPS-1:0] irq_d;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [31:0] MEMBERS = group_members(g, LINES);
    assign irq_d[g] = |(fire & MEMBERS[LINES-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int LINES = LINES_DEF,
  parameter int PORTS = PORTS_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [PORTS*PORT_W-1:0]   pin_level,
  input  logic [LINES*SEL_W-1:0]    port_sel,
  output logic [LINES-1:0]          pend_status,
  output logic [GROUPS-1:0]         irq_pulse
);
  localparam int PIN_W = PORTS * PORT_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [PIN_W-1:0] rise_all, fall_all;
  logic [LINES-1:0] line_rise, line_fall, fire, enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  eic_edge_detect #(.W(PIN_W)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .level(pin_level),
    .rise(rise_all), .fall(fall_all)
  );

  eic_line_router #(.LINES(LINES), .PORTS(PORTS), .PORT_W(PORT_W), .SEL_W(SEL_W)) u_route (
    .rise_all(rise_all), .fall_all(fall_all), .port_sel(port_sel),
    .line_rise(line_rise), .line_fall(line_fall)
  );

  eic_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_rise(line_rise), .line_fall(line_fall),
    .fire(fire), .enable_q(enable_q), .pend_q(pend_status)
  );

  eic_irq_group #(.LINES(LINES)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire), .irq_q(irq_pulse)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import edge_irq_pkg::*;
#(
  parameter int LINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [LINES-1:0]  enable_q,
  input logic [LINES-1:0]  pend,
  input logic [GROUPS-1:0] irq
);
  // R2: a pending clear with no new firing leaves the written bits at zero
  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && reg_addr == OFF_PEND) && irq == '0)
      |-> ((pend & $past(reg_wdata[LINES-1:0])) == '0));

  // R5: a pending bit only rises on a line that was enabled
  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(enable_q)) == '0));

  // R6: a newly pending line always comes with a request pulse
  assert_pend_has_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> (irq != '0));

  // R6: a request pulse always leaves something pending
  assert_irq_has_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (pend != '0));
endmodule

bind edge_irq_ctrl eic_checker #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .enable_q(enable_q), .pend(pend_status),
  .irq(irq_pulse)
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  import edge_irq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int L = 16;
  localparam int P = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic [P*16-1:0]   pin_level;
  logic [L*4-1:0]    port_sel;
  logic [L-1:0]      pend_status;
  logic [6:0]        irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_level(pin_level),
    .port_sel(port_sel), .pend_status(pend_status), .irq_pulse(irq_pulse)
  );

  typedef struct packed {
    logic [3:0] line;
    logic [2:0] port;   // port whose pin toggles
    logic [3:0] code;   // port code given to the line
    logic       en;
    logic       arm_r;
    logic       arm_f;
    logic       rising;
    logic       expect_fire;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  3'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 port A rise
    '{4'd2,  3'd1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 wrong port
    '{4'd7,  3'd2, 4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 fall-only, rising edge
    '{4'd7,  3'd2, 4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 fall-only, falling edge
    '{4'd12, 3'd4, 4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 port E, group 6
    '{4'd12, 3'd4, 4'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 disabled
    '{4'd0,  3'd3, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R6 line 0 port D
    '{4'd15, 3'd4, 4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 code selects no port
    '{4'd9,  3'd1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}   // R6 line 9 shared group
  };

  function automatic int grp_of(input int line);
    if (line < 5) return line;
    else if (line < 10) return 5;
    else return 6;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_level = '0; port_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(ADDR_W'(a*4), r);
      check("R1 reset reg", r, 32'h0);
    end
    check("R1 reset pend", 32'(pend_status), 32'h0);
    check("R1 reset irq", 32'(irq_pulse), 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int pin;
      t = VECS[v];
      pin = int'(t.port) * 16 + int'(t.line);
      wr(OFF_ENABLE, 32'h0);
      port_sel = '0;
      port_sel[t.line*4 +: 4] = t.code;
      pin_level = '0;
      pin_level[pin] = ~t.rising;
      repeat (2) @(negedge clk);
      wr(OFF_RISE, t.arm_r ? (32'h1 << t.line) : 32'h0);
      wr(OFF_FALL, t.arm_f ? (32'h1 << t.line) : 32'h0);
      wr(OFF_PEND, 32'hFFFF);
      wr(OFF_ENABLE, t.en ? (32'h1 << t.line) : 32'h0);
      check($sformatf("R9 vec%0d quiet before edge", v), 32'(pend_status), 32'h0);
      pin_level[pin] = t.rising;
      @(negedge clk);
      check($sformatf("R3 R4 R5 vec%0d pend", v), 32'(pend_status),
            t.expect_fire ? (32'h1 << t.line) : 32'h0);
      check($sformatf("R6 vec%0d irq", v), 32'(irq_pulse),
            t.expect_fire ? (32'h1 << grp_of(int'(t.line))) : 32'h0);
      @(negedge clk);
      check($sformatf("R9 vec%0d pulse ends", v), 32'(irq_pulse), 32'h0);
    end
    rd(OFF_PEND, r);
    check("R1 pend readback", r, 32'h200);

    // R1 register map readback and unknown offset
    wr(OFF_ENABLE, 32'hFFFF_0003); rd(OFF_ENABLE, r); check("R1 enable rb", r, 32'h0003);
    wr(OFF_RISE, 32'h0000_1234);   rd(OFF_RISE, r);   check("R1 rise rb", r, 32'h1234);
    wr(OFF_FALL, 32'h0000_8001);   rd(OFF_FALL, r);   check("R1 fall rb", r, 32'h8001);
    rd(6'h18, r); check("R1 unmapped", r, 32'h0);
    rd(6'h02, r); check("R1 unaligned", r, 32'h0);

    // R2 write-one-to-clear: pend holds line 9 from the table; add line 0
    wr(OFF_ENABLE, 32'h0001);
    wr(OFF_SWFIRE, 32'h0001);
    check("R2 setup", 32'(pend_status), 32'h0201);
    wr(OFF_PEND, 32'h0000_0001);
    check("R2 clear one bit", 32'(pend_status), 32'h0200);
    wr(OFF_PEND, 32'h0);
    check("R2 zero write keeps", 32'(pend_status), 32'h0200);
    wr(OFF_PEND, 32'hFFFF);

    // R7 event mask stores all bits, does nothing
    wr(OFF_ENABLE, 32'h0);
    wr(OFF_RISE, 32'hFFFF);
    wr(OFF_EVMASK, 32'hDEAD_BEEF);
    rd(OFF_EVMASK, r); check("R7 evmask rb", r, 32'hDEAD_BEEF);
    port_sel = '0;
    pin_level = '0;
    @(negedge clk);
    pin_level[15:0] = 16'hFFFF;
    @(negedge clk);
    check("R7 no pend", 32'(pend_status), 32'h0);
    check("R7 no irq", 32'(irq_pulse), 32'h0);
    pin_level = '0;
    @(negedge clk);

    // R8 software fire
    wr(OFF_ENABLE, 32'h0008);
    wr(OFF_SWFIRE, 32'h0028);   // line 3 enabled, line 5 not
    check("R8 sw pend", 32'(pend_status), 32'h0008);
    check("R8 sw irq", 32'(irq_pulse), 32'h0008);
    @(negedge clk);
    check("R8 sw pulse ends", 32'(irq_pulse), 32'h0);
    rd(OFF_SWFIRE, r); check("R8 swfire held", r, 32'h0028);
    wr(OFF_PEND, 32'h0008);
    rd(OFF_SWFIRE, r); check("R8 swfire cleared with pend", r, 32'h0020);
    check("R8 pend cleared", 32'(pend_status), 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule